// File: doc/BRIEF.md
# AXI ID Transaction Filter

This block sits between a memory port's transaction sideband and a bank of event counters. For each of its counter lanes it takes an event code. When the code is the read-by-ID event (0x41) or the write-by-ID event (0x42), the lane emits a pulse for each completed transaction whose ID passes a programmed compare/mask test. Every other event code passes that lane's raw event strobe straight through. The counters themselves sit outside the block. It receives only a one-cycle `cnt_hit` flag and an increment value per lane.

A small mode state machine chooses how the lanes qualify transactions. In the two shared states, every lane tests against one common ID/mask register. In the two per-lane states, each lane uses its own ID/mask register and also a port/channel selector register. The burst states put out an increment of one. The byte states put out the transaction's byte count for ID-filtered lanes. The states are MD_SHARED_BURST, MD_SHARED_BYTES, MD_PORT_BURST and MD_PORT_BYTES. The only transition is a write to the control register, which moves the machine to the state encoded in write-data bits [1:0] (0, 1, 2, 3 in that order). Without such a write the state is held.

Top module: `axid_txn_filter`

## Requirements
- R1: After reset, `cnt_hit` and `cnt_inc` are zero and the machine is in MD_SHARED_BURST. The shared register (offset 0x30) and all per-lane registers are zero, so a read transaction with ID 0 matches a 0x41 lane and one with ID 1 does not.
- R2: A lane whose event code is neither 0x41 nor 0x42 raises `cnt_hit` with increment 1 in the cycle after its `raw_strobe` bit is high. Transactions do not affect it, in any state.
- R3: A 0x41 lane hits only on a completed read transaction (`txn_write`=0) whose ID passes the test ((txn_id XOR id) AND NOT stored_mask) == 0. In the shared states, id is bits [15:0] and stored_mask is bits [31:16] of the register at 0x30.
- R4: A stored mask bit of 1 makes that ID bit don't-care. A stored mask of all ones matches every ID.
- R5: A 0x42 lane hits only on completed write transactions (`txn_write`=1), under the same ID test.
- R6: A transaction counts only when `txn_valid` and `txn_ready` are both high. Valid without ready gives no hit on an ID-filtered lane.
- R7: The control register is at offset 0x00: bit 0 selects bytes, bit 1 selects per-lane. In the byte states, an ID-filtered hit carries `txn_bytes` as its increment. In the burst states, and for pass-through lanes, the increment is 1.
- R8: In the per-lane states, lane n (0-based) tests the ID against its own register at 0x54 + 16*n, with the same layout, and ignores the shared register.
- R9: In the per-lane states, lane n also requires a match against its selector at 0x50 + 16*n. A 0x41 lane needs `txn_port` equal to bits [2:0] and `txn_chan` equal to the inverse of bit 3. A 0x42 lane needs `txn_port` equal to bits [10:8] and `txn_chan` equal to the inverse of bit 11.
- R10: Outputs are registered. Each qualifying handshake gives exactly one hit in the following cycle. `cnt_inc` is zero whenever `cnt_hit` is low.
- R11: A register write and a transaction in the same cycle: the transaction is judged against the register values from before the write.
- R12: Writes to unmapped offsets change no register and no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| cnt_event | input | NCNT*8 | Event code per lane, lane 0 in the low byte |
| raw_strobe | input | NCNT | Unfiltered event strobe per lane |
| txn_valid | input | 1 | Transaction valid |
| txn_ready | input | 1 | Transaction ready |
| txn_id | input | 16 | Transaction ID |
| txn_port | input | 3 | Port number of the transaction |
| txn_write | input | 1 | 1 = write, 0 = read |
| txn_chan | input | 1 | Channel tag of the transaction |
| txn_bytes | input | 8 | Bytes moved by the transaction |
| cnt_hit | output | NCNT | One-cycle hit per lane |
| cnt_inc | output | NCNT*8 | Increment per lane, lane 0 in the low byte |

## Verification
A register write and a completed transaction can fall in the same cycle. The write may retarget the very lane the transaction is being judged on, or switch the mode state. A directed step programs a match and then, in a single cycle, both rewrites it to a non-matching value and presents a matching transaction. A random phase then mixes writes to every mapped and one unmapped offset with handshakes, valid-only cycles and raw strobes. The behavioural model in the bench evaluates each edge against the pre-write configuration before applying the write. It is compared with both outputs of every lane on every clock.

// File: rtl/axid_filt_pkg.sv
package axid_filt_pkg;
    // register offsets (byte addresses)
    localparam int OFS_CTRL      = 'h00;
    localparam int OFS_SHARED    = 'h30;
    localparam int OFS_PC_MUX    = 'h50;
    localparam int OFS_PC_IDM    = 'h54;
    localparam int OFS_PC_STRIDE = 'h10;

    // event codes that go through the ID filter
    localparam logic [7:0] EV_RD_BY_ID = 8'h41;
    localparam logic [7:0] EV_WR_BY_ID = 8'h42;

    // field positions inside the ID/mask and selector registers
    localparam int MASK_LSB      = 16;
    localparam int SEL_RCH_BIT   = 3;
    localparam int SEL_WPORT_LSB = 8;
    localparam int SEL_WCH_BIT   = 11;

    typedef enum logic [1:0] {
        MD_SHARED_BURST = 2'd0,
        MD_SHARED_BYTES = 2'd1,
        MD_PORT_BURST   = 2'd2,
        MD_PORT_BYTES   = 2'd3
    } mode_e;
endpackage

// File: rtl/axid_filt_regs.sv
module axid_filt_regs
    import axid_filt_pkg::*;
#(
    parameter int NCNT   = 3,
    parameter int REG_AW = 8,
    parameter int REG_DW = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic [REG_AW-1:0]             reg_addr,
    input  logic [REG_DW-1:0]             reg_wdata,
    output logic [REG_DW-1:0]             shared_q,
    output logic [NCNT-1:0][REG_DW-1:0]   pc_idm_q,
    output logic [NCNT-1:0][REG_DW-1:0]   pc_sel_q,
    output logic                          byte_mode,
    output logic                          port_mode
);
    localparam logic [REG_AW-1:0] A_CTRL   = REG_AW'(OFS_CTRL);
    localparam logic [REG_AW-1:0] A_SHARED = REG_AW'(OFS_SHARED);

    mode_e mode_q, mode_d;

    logic                 wr_ctrl, wr_shared;
    logic [NCNT-1:0]      wr_idm, wr_sel;
    logic                 addr_mapped;

    assign wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
    assign wr_shared = reg_wr && (reg_addr == A_SHARED);

    // per-lane register decode and storage
    for (genvar g = 0; g < NCNT; g++) begin : g_lane_regs
        localparam logic [REG_AW-1:0] A_IDM = REG_AW'(OFS_PC_IDM + OFS_PC_STRIDE * g);
        localparam logic [REG_AW-1:0] A_SEL = REG_AW'(OFS_PC_MUX + OFS_PC_STRIDE * g);

        assign wr_idm[g] = reg_wr && (reg_addr == A_IDM);
        assign wr_sel[g] = reg_wr && (reg_addr == A_SEL);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pc_idm_q[g] <= '0;
                pc_sel_q[g] <= '0;
            end else begin
                if (wr_idm[g]) pc_idm_q[g] <= reg_wdata;
                if (wr_sel[g]) pc_sel_q[g] <= reg_wdata;
            end
        end
    end

    assign addr_mapped = (reg_addr == A_CTRL) || (reg_addr == A_SHARED) ||
                         (|(wr_idm | wr_sel));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shared_q <= '0;
        end else if (wr_shared) begin
            shared_q <= reg_wdata;
        end
    end

    // mode state machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MD_SHARED_BURST;
        end else begin
            mode_q <= mode_d;
        end
    end

    // mode state machine: next state
    always_comb begin
        mode_d = mode_q;
        if (wr_ctrl) begin
            unique case (mode_e'(reg_wdata[1:0]))
                MD_SHARED_BURST: mode_d = MD_SHARED_BURST;
                MD_SHARED_BYTES: mode_d = MD_SHARED_BYTES;
                MD_PORT_BURST:   mode_d = MD_PORT_BURST;
                MD_PORT_BYTES:   mode_d = MD_PORT_BYTES;
            endcase
        end
    end

    // mode state machine: outputs
    always_comb begin
        byte_mode = 1'b0;
        port_mode = 1'b0;
        unique case (mode_q)
            MD_SHARED_BURST: begin byte_mode = 1'b0; port_mode = 1'b0; end
            MD_SHARED_BYTES: begin byte_mode = 1'b1; port_mode = 1'b0; end
            MD_PORT_BURST:   begin byte_mode = 1'b0; port_mode = 1'b1; end
            MD_PORT_BYTES:   begin byte_mode = 1'b1; port_mode = 1'b1; end
        endcase
    end

    AST_CTRL_SELECTS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (mode_q == mode_e'($past(reg_wdata[1:0])))); // R7

    AST_UNMAPPED_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !addr_mapped) |=> ($stable(shared_q) && $stable(mode_q) &&
                                      $stable(pc_idm_q) && $stable(pc_sel_q))); // R12
endmodule

// File: rtl/axid_filt_match.sv
module axid_filt_match
    import axid_filt_pkg::*;
#(
    parameter int ID_W   = 16,
    parameter int PORT_W = 3,
    parameter int EV_W   = 8,
    parameter int REG_DW = 32
) (
    input  logic [EV_W-1:0]   ev_code,
    input  logic [REG_DW-1:0] shared_q,
    input  logic [REG_DW-1:0] lane_idm,
    input  logic [REG_DW-1:0] lane_sel,
    input  logic              port_mode,
    input  logic              raw_strobe,
    input  logic              txn_fire,
    input  logic [ID_W-1:0]   txn_id,
    input  logic [PORT_W-1:0] txn_port,
    input  logic              txn_write,
    input  logic              txn_chan,
    output logic              hit,
    output logic              filtered
);
    logic [REG_DW-1:0] idm;
    logic [ID_W-1:0]   care;
    logic              is_rd, is_wr, id_ok, dir_ok, lane_ok;
    logic [PORT_W-1:0] want_port;
    logic              chan_inv;

    assign is_rd    = (ev_code == EV_W'(EV_RD_BY_ID));
    assign is_wr    = (ev_code == EV_W'(EV_WR_BY_ID));
    assign filtered = is_rd || is_wr;

    // the ID/mask source follows the mode
    assign idm   = port_mode ? lane_idm : shared_q;
    assign care  = ~idm[MASK_LSB +: ID_W];
    assign id_ok = ((txn_id ^ idm[ID_W-1:0]) & care) == '0;

    assign dir_ok = is_rd ? !txn_write : txn_write;

    // port/channel selector (channel bit stored inverted)
    assign want_port = is_rd ? lane_sel[PORT_W-1:0] : lane_sel[SEL_WPORT_LSB +: PORT_W];
    assign chan_inv  = is_rd ? lane_sel[SEL_RCH_BIT] : lane_sel[SEL_WCH_BIT];
    assign lane_ok   = !port_mode || ((txn_port == want_port) && (txn_chan != chan_inv));

    always_comb begin
        if (filtered) begin
            hit = txn_fire && dir_ok && id_ok && lane_ok;
        end else begin
            hit = raw_strobe;
        end
    end
endmodule

// File: rtl/axid_filt_out.sv
module axid_filt_out #(
    parameter int NCNT   = 3,
    parameter int BYTE_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCNT-1:0]        hit,
    input  logic [NCNT-1:0]        use_bytes,
    input  logic [BYTE_W-1:0]      txn_bytes,
    output logic [NCNT-1:0]        cnt_hit,
    output logic [NCNT*BYTE_W-1:0] cnt_inc
);
    for (genvar g = 0; g < NCNT; g++) begin : g_lane_out
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_hit[g]                 <= 1'b0;
                cnt_inc[g*BYTE_W +: BYTE_W] <= '0;
            end else begin
                cnt_hit[g] <= hit[g];
                if (!hit[g]) begin
                    cnt_inc[g*BYTE_W +: BYTE_W] <= '0;
                end else if (use_bytes[g]) begin
                    cnt_inc[g*BYTE_W +: BYTE_W] <= txn_bytes;
                end else begin
                    cnt_inc[g*BYTE_W +: BYTE_W] <= BYTE_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/axid_txn_filter.sv
module axid_txn_filter
    import axid_filt_pkg::*;
#(
    parameter int NCNT   = 3,
    parameter int ID_W   = 16,
    parameter int PORT_W = 3,
    parameter int EV_W   = 8,
    parameter int BYTE_W = 8,
    parameter int REG_AW = 8,
    parameter int REG_DW = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [REG_AW-1:0]      reg_addr,
    input  logic [REG_DW-1:0]      reg_wdata,
    input  logic [NCNT*EV_W-1:0]   cnt_event,
    input  logic [NCNT-1:0]        raw_strobe,
    input  logic                   txn_valid,
    input  logic                   txn_ready,
    input  logic [ID_W-1:0]        txn_id,
    input  logic [PORT_W-1:0]      txn_port,
    input  logic                   txn_write,
    input  logic                   txn_chan,
    input  logic [BYTE_W-1:0]      txn_bytes,
    output logic [NCNT-1:0]        cnt_hit,
    output logic [NCNT*BYTE_W-1:0] cnt_inc
);
    logic [REG_DW-1:0]           shared_q;
    logic [NCNT-1:0][REG_DW-1:0] pc_idm_q;
    logic [NCNT-1:0][REG_DW-1:0] pc_sel_q;
    logic                        byte_mode, port_mode;
    logic                        txn_fire;
    logic [NCNT-1:0]             hit_comb, filtered, use_bytes;

    assign txn_fire = txn_valid && txn_ready;

    axid_filt_regs #(
        .NCNT(NCNT), .REG_AW(REG_AW), .REG_DW(REG_DW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .shared_q(shared_q), .pc_idm_q(pc_idm_q), .pc_sel_q(pc_sel_q),
        .byte_mode(byte_mode), .port_mode(port_mode)
    );

    for (genvar g = 0; g < NCNT; g++) begin : g_lane
        axid_filt_match #(
            .ID_W(ID_W), .PORT_W(PORT_W), .EV_W(EV_W), .REG_DW(REG_DW)
        ) u_match (
            .ev_code(cnt_event[g*EV_W +: EV_W]),
            .shared_q(shared_q),
            .lane_idm(pc_idm_q[g]),
            .lane_sel(pc_sel_q[g]),
            .port_mode(port_mode),
            .raw_strobe(raw_strobe[g]),
            .txn_fire(txn_fire),
            .txn_id(txn_id),
            .txn_port(txn_port),
            .txn_write(txn_write),
            .txn_chan(txn_chan),
            .hit(hit_comb[g]),
            .filtered(filtered[g])
        );

        assign use_bytes[g] = filtered[g] && byte_mode;

        AST_INC_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !cnt_hit[g] |-> (cnt_inc[g*BYTE_W +: BYTE_W] == '0)); // R10

        AST_BURST_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
            (!byte_mode && hit_comb[g]) |=> (cnt_inc[g*BYTE_W +: BYTE_W] == BYTE_W'(1))); // R7

        AST_RAW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            (!filtered[g] && raw_strobe[g]) |=> cnt_hit[g]); // R2

        AST_FILTERED_NEEDS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
            (filtered[g] && !txn_fire) |=> !cnt_hit[g]); // R6
    end

    axid_filt_out #(
        .NCNT(NCNT), .BYTE_W(BYTE_W)
    ) u_out (
        .clk(clk), .rst_n(rst_n),
        .hit(hit_comb), .use_bytes(use_bytes), .txn_bytes(txn_bytes),
        .cnt_hit(cnt_hit), .cnt_inc(cnt_inc)
    );

    AST_QUIET_NO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!txn_fire && (raw_strobe == '0)) |=> (cnt_hit == '0)); // R6
endmodule

// File: tb/test_axid_txn_filter.sv
`timescale 1ns/1ps
module test_axid_txn_filter;
    localparam int NCNT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [7:0]  ev [NCNT];
    logic [NCNT-1:0] raw_strobe = '0;
    logic        txn_valid = 1'b0, txn_ready = 1'b0;
    logic [15:0] txn_id = '0;
    logic [2:0]  txn_port = '0;
    logic        txn_write = 1'b0, txn_chan = 1'b0;
    logic [7:0]  txn_bytes = 8'd1;
    logic [NCNT-1:0]   cnt_hit;
    logic [NCNT*8-1:0] cnt_inc;
    logic [NCNT*8-1:0] cnt_event;

    assign cnt_event = {ev[2], ev[1], ev[0]};

    always #4 clk = ~clk;

    axid_txn_filter i_axid_txn_filter (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .cnt_event(cnt_event), .raw_strobe(raw_strobe),
        .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_id(txn_id),
        .txn_port(txn_port), .txn_write(txn_write), .txn_chan(txn_chan),
        .txn_bytes(txn_bytes), .cnt_hit(cnt_hit), .cnt_inc(cnt_inc)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    chk_en = 1'b0;
    bit    done = 1'b0;

    // behavioural reference model
    logic [1:0]  m_ctrl;
    logic [31:0] m_sh;
    logic [31:0] m_idm [NCNT];
    logic [31:0] m_sel [NCNT];
    logic [NCNT-1:0] exp_hit = '0;
    int          exp_inc [NCNT];

    initial for (int n = 0; n < NCNT; n++) begin ev[n] = 8'h05; exp_inc[n] = 0; end

    function automatic bit model_hit(int n);
        logic [31:0] src;
        bit rd, wr, ok;
        rd = (ev[n] == 8'h41);
        wr = (ev[n] == 8'h42);
        if (!rd && !wr) return raw_strobe[n];
        if (!(txn_valid && txn_ready)) return 0;
        if (rd && txn_write) return 0;
        if (wr && !txn_write) return 0;
        src = m_ctrl[1] ? m_idm[n] : m_sh;
        for (int b = 0; b < 16; b++)
            if (!src[16+b] && (txn_id[b] != src[b])) return 0;
        ok = 1;
        if (m_ctrl[1]) begin
            if (rd) ok = (txn_port == m_sel[n][2:0]) && (txn_chan == !m_sel[n][3]);
            else    ok = (txn_port == m_sel[n][10:8]) && (txn_chan == !m_sel[n][11]);
        end
        return ok;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = '0; m_sh = '0;
            for (int n = 0; n < NCNT; n++) begin m_idm[n] = '0; m_sel[n] = '0; exp_inc[n] = 0; end
            exp_hit = '0;
        end else begin
            for (int n = 0; n < NCNT; n++) begin
                exp_hit[n] = model_hit(n);
                if (!exp_hit[n]) exp_inc[n] = 0;
                else if (m_ctrl[0] && (ev[n] == 8'h41 || ev[n] == 8'h42)) exp_inc[n] = txn_bytes;
                else exp_inc[n] = 1;
            end
            if (reg_wr) begin
                if (reg_addr == 8'h00) m_ctrl = reg_wdata[1:0];
                if (reg_addr == 8'h30) m_sh = reg_wdata;
                for (int n = 0; n < NCNT; n++) begin
                    if (reg_addr == 8'(8'h54 + 16*n)) m_idm[n] = reg_wdata;
                    if (reg_addr == 8'(8'h50 + 16*n)) m_sel[n] = reg_wdata;
                end
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (chk_en && !done) begin
            for (int n = 0; n < NCNT; n++) begin
                checks++;
                if (cnt_hit[n] !== exp_hit[n] || int'(cnt_inc[n*8 +: 8]) != exp_inc[n]) begin
                    errors++;
                    $display("FAIL %s lane %0d t=%0t: hit/inc actual %b/%0d expected %b/%0d",
                             cur_req, n, $time, cnt_hit[n], cnt_inc[n*8 +: 8], exp_hit[n], exp_inc[n]);
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic txn(input logic v, input logic r, input logic [15:0] id, input logic [2:0] p,
                       input logic w, input logic ch, input logic [7:0] by);
        txn_valid = v; txn_ready = r; txn_id = id; txn_port = p;
        txn_write = w; txn_chan = ch; txn_bytes = by;
        tick();
        txn_valid = 1'b0; txn_ready = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL R10 watchdog: actual still running, expected finished");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        // R1: explicit reset-state check
        checks++;
        if (cnt_hit !== '0 || cnt_inc !== '0) begin
            errors++;
            $display("FAIL R1 reset outputs: actual %b/%h expected 0/0", cnt_hit, cnt_inc);
        end
        chk_en = 1'b1;

        // R1: default config matches ID 0 only
        cur_req = "R1";
        ev[0] = 8'h41; ev[1] = 8'h42; ev[2] = 8'h05;
        txn(1, 1, 16'h0000, 0, 0, 0, 8'd4);
        txn(1, 1, 16'h0001, 0, 0, 0, 8'd4);
        tick();

        // R2: raw strobes pass on unfiltered lane only
        cur_req = "R2";
        raw_strobe = 3'b111; tick(); tick();
        raw_strobe = 3'b100; txn(1, 1, 16'h0000, 0, 1, 0, 8'd9);
        raw_strobe = '0; tick();

        // R3: shared compare with partial mask
        cur_req = "R3";
        wr_reg(8'h30, {16'hFF00, 16'h1234});
        txn(1, 1, 16'h5634, 0, 0, 0, 8'd2);
        txn(1, 1, 16'h1235, 0, 0, 0, 8'd2);
        txn(1, 1, 16'h0034, 5, 0, 1, 8'd2);
        tick();

        // R4: all don't-care
        cur_req = "R4";
        wr_reg(8'h30, {16'hFFFF, 16'h0000});
        txn(1, 1, 16'hBEEF, 0, 0, 0, 8'd2);
        txn(1, 1, 16'h7001, 0, 1, 0, 8'd2);

        // R5: write event sees writes only
        cur_req = "R5";
        wr_reg(8'h30, {16'h0000, 16'h00A5});
        txn(1, 1, 16'h00A5, 0, 1, 0, 8'd3);
        txn(1, 1, 16'h00A5, 0, 0, 0, 8'd3);
        txn(1, 1, 16'h00A4, 0, 1, 0, 8'd3);

        // R6: valid without ready, ready without valid
        cur_req = "R6";
        txn(1, 0, 16'h00A5, 0, 1, 0, 8'd3);
        txn(0, 1, 16'h00A5, 0, 0, 0, 8'd3);
        tick();

        // R7: byte mode
        cur_req = "R7";
        wr_reg(8'h00, 32'h1);
        raw_strobe = 3'b100;
        txn(1, 1, 16'h00A5, 0, 1, 0, 8'd200);
        txn(1, 1, 16'h00A5, 0, 0, 0, 8'd64);
        raw_strobe = '0;
        wr_reg(8'h00, 32'h0);
        txn(1, 1, 16'h00A5, 0, 0, 0, 8'd64);

        // R8: per-lane ID registers, shared ignored
        cur_req = "R8";
        ev[2] = 8'h41;
        wr_reg(8'h54, {16'h0000, 16'h0011});
        wr_reg(8'h64, {16'h0000, 16'h0022});
        wr_reg(8'h74, {16'h000F, 16'h0030});
        wr_reg(8'h50, 32'h0000_0008);  // read port 0, read chan 0
        wr_reg(8'h60, 32'h0000_0800);  // write port 0, write chan 0
        wr_reg(8'h70, 32'h0000_0008);
        wr_reg(8'h00, 32'h2);
        txn(1, 1, 16'h0011, 0, 0, 0, 8'd5);
        txn(1, 1, 16'h0022, 0, 1, 0, 8'd5);
        txn(1, 1, 16'h003C, 0, 0, 0, 8'd5);
        txn(1, 1, 16'h00A5, 0, 0, 0, 8'd5);

        // R9: port and inverted channel selectors
        cur_req = "R9";
        wr_reg(8'h50, 32'h0000_0005);  // read port 5, stored chan 0 -> need chan 1
        wr_reg(8'h60, 32'h0000_0300);  // write port 3, stored chan 0 -> need chan 1
        txn(1, 1, 16'h0011, 5, 0, 1, 8'd5);
        txn(1, 1, 16'h0011, 5, 0, 0, 8'd5);
        txn(1, 1, 16'h0011, 4, 0, 1, 8'd5);
        txn(1, 1, 16'h0022, 3, 1, 1, 8'd5);
        txn(1, 1, 16'h0022, 3, 1, 0, 8'd5);
        wr_reg(8'h00, 32'h3);
        txn(1, 1, 16'h0022, 3, 1, 1, 8'd77);

        // R11: write and transaction in the same cycle
        cur_req = "R11";
        reg_wr = 1'b1; reg_addr = 8'h54; reg_wdata = {16'h0000, 16'h0099};
        txn(1, 1, 16'h0011, 5, 0, 1, 8'd12);
        reg_wr = 1'b0;
        txn(1, 1, 16'h0011, 5, 0, 1, 8'd12);
        reg_wr = 1'b1; reg_addr = 8'h00; reg_wdata = 32'h0;
        txn(1, 1, 16'h0099, 5, 0, 1, 8'd12);
        reg_wr = 1'b0;
        tick();

        // R12: unmapped writes ignored
        cur_req = "R12";
        wr_reg(8'h40, 32'hFFFF_FFFF);
        wr_reg(8'h34, 32'hFFFF_FFFF);
        wr_reg(8'h58, 32'hFFFF_FFFF);
        txn(1, 1, 16'h00A5, 0, 0, 0, 8'd6);
        txn(1, 1, 16'h1111, 0, 0, 0, 8'd6);

        // R10: random mix
        cur_req = "R10";
        for (int i = 0; i < 600; i++) begin
            int sel;
            sel = int'($urandom % 9);
            reg_wr = ($urandom % 6) == 0;
            case (sel)
                0: reg_addr = 8'h00; 1: reg_addr = 8'h30; 2: reg_addr = 8'h50;
                3: reg_addr = 8'h54; 4: reg_addr = 8'h60; 5: reg_addr = 8'h64;
                6: reg_addr = 8'h70; 7: reg_addr = 8'h74; default: reg_addr = 8'h44;
            endcase
            reg_wdata = $urandom & 32'hFFF3_0F0F;
            if (($urandom % 20) == 0) ev[$urandom % NCNT] = (($urandom % 3) == 0) ? 8'h05 :
                                                          (($urandom % 2) == 0) ? 8'h41 : 8'h42;
            raw_strobe = 3'($urandom);
            txn_valid = ($urandom % 4) != 0;
            txn_ready = ($urandom % 3) != 0;
            txn_id    = 16'($urandom & 32'h0000_000F);
            txn_port  = 3'($urandom % 2);
            txn_write = 1'($urandom);
            txn_chan  = 1'($urandom);
            txn_bytes = 8'($urandom);
            tick();
        end
        reg_wr = 1'b0; txn_valid = 1'b0; raw_strobe = '0;
        tick(); tick();
        finish_run();
    end
endmodule